// File: doc/BRIEF.md
# Strobe-Windowed Gated One-Hot Select Decoder

This block converts a small binary command field from a processor I/O bus into a set of active-high, one-hot select lines. A line is driven only inside a time window. The window opens when the first timing strobe goes from high to low. It closes when the second timing strobe goes from high to low. A chip-enable input qualifies both the window and the lines. A higher-level decoder can therefore enable one of several of these blocks, which gives multi-level I/O decoding.

Everything runs on a fast system clock. Each strobe passes through a synchronising shift register. A falling edge is recognised when the older sample is high and the newer sample is low. A single window flag records whether the window is open. The select lines are registered from that flag, the chip enable and the command field. With the default two synchroniser stages, a line changes on the fourth clock edge after its strobe input falls. The first of those four edges is the one that first samples the new strobe level. A change of chip enable or of the command field shows at the lines on the next edge.

Top module: `wdec_strobe_decoder`

## Requirements
- R1: A synchronous active-high reset closes the window and drives all select lines low on the next edge. The lines stay low afterwards until strobe A falls again.
- R2: Command value k (bit 0 least significant) drives line k only. Line k is bit k of `lines_o`. At no time is more than one line high.
- R3: With chip enable high, a high-to-low change of strobe A opens the window. The selected line rises on the fourth clock edge after the strobe input falls and is still low after the third edge.
- R4: A high-to-low change of strobe B closes the window. The line falls on the fourth clock edge after the strobe input falls and is still high after the third edge.
- R5: Rising edges and steady levels of either strobe leave the window in its previous state.
- R6: When chip enable is low, all lines are low from the next clock edge, whatever the strobes and the command field do.
- R7: Chip enable low closes the window. When chip enable returns high, the lines stay low until strobe A falls again.
- R8: If the falling edges of strobes A and B are detected in the same clock cycle, the window closes.
- R9: While the window is open and chip enable is high, a change of the command field moves the active line on the next clock edge.
- R10: A fall of strobe A while the window is open keeps it open. A fall of strobe B while the window is closed keeps it closed.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | System clock |
| rst_i | input | 1 | Synchronous active-high reset |
| ce_i | input | 1 | Chip enable, active high |
| stb_a_i | input | 1 | Strobe whose falling edge opens the window |
| stb_b_i | input | 1 | Strobe whose falling edge closes the window |
| cmd_i | input | SEL_W (3) | Binary command field |
| lines_o | output | 2**SEL_W (8) | One-hot select lines, active high |

## Verification
The bench builds the block with its defaults: a 3-bit command field, eight lines and two synchroniser stages. This keeps the whole command space within reach. Every value is used to open a window, and every other value is then swept inside that open window. The short synchroniser makes the four-edge latency small enough to check the edge before and the edge of each transition. This covers simultaneous strobe edges, rising-edge immunity, chip-enable drops and reset in the middle of a window.

// File: rtl/wdec_pkg.sv
package wdec_pkg;

    localparam int unsigned SEL_W_DEF = 3;
    localparam int unsigned SYNC_DEF  = 2;

    typedef enum logic {
        WIN_SHUT = 1'b0,
        WIN_OPEN = 1'b1
    } win_state_e;

    function automatic logic [(1 << SEL_W_DEF) - 1:0] onehot_of(
        input logic [SEL_W_DEF - 1:0] code
    );
        logic [(1 << SEL_W_DEF) - 1:0] v;
        v = '0;
        v[code] = 1'b1;
        return v;
    endfunction

endpackage

// File: rtl/wdec_fall_detect.sv
module wdec_fall_detect #(
    parameter int unsigned STAGES = 2
) (
    input  logic clk_i,
    input  logic rst_i,
    input  logic level_i,
    output logic fall_o
);
    typedef struct packed {
        logic [STAGES-1:0] shift;
        logic              prev;
    } sync_t;

    sync_t st_d, st_q;

    always_comb begin
        st_d       = st_q;
        st_d.shift = {st_q.shift[STAGES-2:0], level_i};
        st_d.prev  = st_q.shift[STAGES-1];
        if (rst_i) begin
            st_d = '0;
        end
    end

    always_ff @(posedge clk_i) begin
        st_q <= st_d;
    end

    assign fall_o = st_q.prev & ~st_q.shift[STAGES-1];

endmodule

// File: rtl/wdec_window.sv
module wdec_window
    import wdec_pkg::*;
(
    input  logic clk_i,
    input  logic rst_i,
    input  logic ce_i,
    input  logic open_i,
    input  logic close_i,
    output logic win_o
);
    win_state_e win_d, win_q;

    always_comb begin
        win_d = win_q;
        if (open_i) begin
            win_d = WIN_OPEN;
        end
        if (close_i || !ce_i || rst_i) begin
            win_d = WIN_SHUT;
        end
    end

    always_ff @(posedge clk_i) begin
        win_q <= win_d;
    end

    assign win_o = (win_q == WIN_OPEN);

endmodule

// File: rtl/wdec_line_drive.sv
module wdec_line_drive #(
    parameter int unsigned SEL_W = 3
) (
    input  logic                     clk_i,
    input  logic                     rst_i,
    input  logic                     ce_i,
    input  logic                     win_i,
    input  logic [SEL_W-1:0]         cmd_i,
    output logic [(1 << SEL_W)-1:0]  lines_o
);
    localparam int unsigned OUT_N = 1 << SEL_W;

    logic [OUT_N-1:0] dec_w;
    logic [OUT_N-1:0] lines_d, lines_q;

    for (genvar g = 0; g < OUT_N; g++) begin : g_line
        assign dec_w[g] = (cmd_i == SEL_W'(g));
    end

    always_comb begin
        lines_d = '0;
        if (ce_i && win_i && !rst_i) begin
            lines_d = dec_w;
        end
    end

    always_ff @(posedge clk_i) begin
        lines_q <= lines_d;
    end

    assign lines_o = lines_q;

endmodule

// File: rtl/wdec_strobe_decoder.sv
module wdec_strobe_decoder #(
    parameter int unsigned SEL_W  = 3,
    parameter int unsigned STAGES = 2,
    localparam int unsigned OUT_N = 1 << SEL_W
) (
    input  logic             clk_i,
    input  logic             rst_i,
    input  logic             ce_i,
    input  logic             stb_a_i,
    input  logic             stb_b_i,
    input  logic [SEL_W-1:0] cmd_i,
    output logic [OUT_N-1:0] lines_o
);
    localparam int unsigned NSTB = 2;

    logic [NSTB-1:0] stb_w;
    logic [NSTB-1:0] fall_w;
    logic            open_w;
    logic            close_w;
    logic            win_w;

    assign stb_w = {stb_b_i, stb_a_i};

    for (genvar s = 0; s < NSTB; s++) begin : g_sync
        wdec_fall_detect #(.STAGES(STAGES)) u_fd (
            .clk_i   (clk_i),
            .rst_i   (rst_i),
            .level_i (stb_w[s]),
            .fall_o  (fall_w[s])
        );
    end

    assign open_w  = fall_w[0];
    assign close_w = fall_w[1];

    wdec_window u_win (
        .clk_i   (clk_i),
        .rst_i   (rst_i),
        .ce_i    (ce_i),
        .open_i  (open_w),
        .close_i (close_w),
        .win_o   (win_w)
    );

    wdec_line_drive #(.SEL_W(SEL_W)) u_drv (
        .clk_i   (clk_i),
        .rst_i   (rst_i),
        .ce_i    (ce_i),
        .win_i   (win_w),
        .cmd_i   (cmd_i),
        .lines_o (lines_o)
    );

endmodule

// File: rtl/wdec_strobe_decoder_chk.sv
module wdec_strobe_decoder_chk #(
    parameter int unsigned SEL_W = 3,
    localparam int unsigned OUT_N = 1 << SEL_W
) (
    input logic             clk_i,
    input logic             rst_i,
    input logic             ce_i,
    input logic [SEL_W-1:0] cmd_i,
    input logic [OUT_N-1:0] lines_o,
    input logic             open_w,
    input logic             close_w,
    input logic             win_w
);
    assert_reset_clear_R1: assert property (@(posedge clk_i)
        rst_i |=> (lines_o == '0 && !win_w));

    assert_onehot_R2: assert property (@(posedge clk_i) disable iff (rst_i)
        $onehot0(lines_o));

    assert_open_R3: assert property (@(posedge clk_i) disable iff (rst_i)
        (open_w && !close_w && ce_i) |=> win_w);

    assert_close_R8: assert property (@(posedge clk_i) disable iff (rst_i)
        close_w |=> !win_w);

    assert_ce_gate_R6: assert property (@(posedge clk_i) disable iff (rst_i)
        !ce_i |=> (lines_o == '0 && !win_w));

    assert_follow_cmd_R9: assert property (@(posedge clk_i) disable iff (rst_i)
        (ce_i && win_w) |=> (lines_o == (OUT_N'(1) << $past(cmd_i))));

    assert_hold_R5: assert property (@(posedge clk_i) disable iff (rst_i)
        (!open_w && !close_w && ce_i) |=> (win_w == $past(win_w)));

endmodule

bind wdec_strobe_decoder wdec_strobe_decoder_chk #(.SEL_W(SEL_W)) u_chk (
    .clk_i   (clk_i),
    .rst_i   (rst_i),
    .ce_i    (ce_i),
    .cmd_i   (cmd_i),
    .lines_o (lines_o),
    .open_w  (open_w),
    .close_w (close_w),
    .win_w   (win_w)
);

// File: tb/sim_wdec_strobe_decoder.sv
`timescale 1ns/1ps
module sim_wdec_strobe_decoder;
    localparam int SEL_W = 3;
    localparam int OUT_N = 1 << SEL_W;
    localparam int LAT   = 4;

    logic             clk = 0;
    logic             rst = 1;
    logic             ce  = 1;
    logic             sa  = 0;
    logic             sb  = 0;
    logic [SEL_W-1:0] cmd = '0;
    logic [OUT_N-1:0] lines;

    int nvec = 0;
    int nbad = 0;
    bit done = 0;

    always #2 clk = ~clk;

    wdec_strobe_decoder u0 (
        .clk_i(clk), .rst_i(rst), .ce_i(ce), .stb_a_i(sa), .stb_b_i(sb),
        .cmd_i(cmd), .lines_o(lines)
    );

    function automatic logic [OUT_N-1:0] exp_line(input int k);
        return OUT_N'(2 ** k);
    endfunction

    task automatic check(input string req, input logic [OUT_N-1:0] exp);
        nvec++;
        if (lines !== exp) begin
            nbad++;
            $display("FAIL %s: lines=%b expected=%b at %0t", req, lines, exp, $time);
        end
    endtask

    task automatic edges(input int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    task automatic raise(input bit a, input bit b);
        @(negedge clk);
        if (a) sa = 1;
        if (b) sb = 1;
        repeat (LAT) @(negedge clk);
    endtask

    task automatic drop(input bit a, input bit b);
        @(negedge clk);
        if (a) sa = 0;
        if (b) sb = 0;
    endtask

    initial begin
        edges(2);
        check("R1 reset", '0);
        @(negedge clk); rst = 0;
        edges(6);
        check("R1 stays closed after reset", '0);

        for (int k = 0; k < OUT_N; k++) begin
            cmd = SEL_W'(k);
            raise(1, 0);
            drop(1, 0);
            edges(LAT - 1);
            check("R3 not yet open", '0);
            edges(1);
            check("R3 open R2 decode", exp_line(k));
            for (int j = 0; j < OUT_N; j++) begin
                @(negedge clk); cmd = SEL_W'(j);
                edges(1);
                check("R9 move R2", exp_line(j));
            end
            @(negedge clk); cmd = SEL_W'(k);
            raise(0, 1);
            drop(0, 1);
            edges(LAT - 1);
            check("R4 still open", exp_line(k));
            edges(1);
            check("R4 closed", '0);
        end

        // R5 rising A does not open
        cmd = 3'd5;
        raise(1, 0);
        edges(2);
        check("R5 rise of A", '0);
        drop(1, 0);
        edges(LAT);
        check("R3 open", exp_line(5));
        raise(0, 1);
        edges(2);
        check("R5 rise of B", exp_line(5));
        // R10 A fall while open keeps open
        raise(1, 0);
        drop(1, 0);
        edges(LAT + 2);
        check("R10 A fall while open", exp_line(5));
        drop(0, 1);
        edges(LAT);
        check("R4 closed by B", '0);
        // R10 B fall while closed
        raise(0, 1);
        drop(0, 1);
        edges(LAT + 2);
        check("R10 B fall while closed", '0);

        // R6/R7 chip enable
        cmd = 3'd2;
        raise(1, 0);
        drop(1, 0);
        edges(LAT);
        check("R3 open before ce drop", exp_line(2));
        @(negedge clk); ce = 0;
        edges(1);
        check("R6 ce low", '0);
        @(negedge clk); cmd = 3'd7;
        edges(1);
        check("R6 cmd ignored", '0);
        @(negedge clk); ce = 1;
        edges(3);
        check("R7 no resume", '0);
        raise(1, 0);
        @(negedge clk); ce = 0; sa = 0;
        edges(LAT + 2);
        check("R6 A fall ignored with ce low", '0);
        @(negedge clk); ce = 1;
        edges(3);
        check("R7 still closed", '0);

        // R8 simultaneous
        raise(1, 0);
        drop(1, 0);
        edges(LAT);
        check("R3 open before tie", exp_line(7));
        raise(1, 1);
        drop(1, 1);
        edges(LAT);
        check("R8 tie closes", '0);
        edges(3);
        check("R8 stays closed", '0);

        // R1 reset mid-window
        raise(1, 0);
        drop(1, 0);
        edges(LAT);
        check("R3 open before reset", exp_line(7));
        @(negedge clk); rst = 1;
        edges(1);
        check("R1 reset mid window", '0);
        @(negedge clk); rst = 0;
        edges(4);
        check("R1 closed after reset", '0);

        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", nvec, nbad);
        $finish;
    end

    initial begin
        #(4 * 100000);
        if (!done) begin
            nbad++;
            $display("FAIL watchdog: lines=%b expected=finish", lines);
            $display("== %0d vectors applied, %0d miscompares ==", nvec, nbad);
            $finish;
        end
    end

endmodule